// File: doc/BRIEF.md
# Mirror-Channel Latency Drift Tracker

This controller tracks how the latency of a transceiver elastic FIFO drifts at run time without disturbing the data path. It serves one or more mission channels that carry traffic and one mirror channel whose FIFO sees the same process, voltage and temperature conditions. Each channel has a phase interpolator that the controller can nudge by one step up or one step down, with no limit on the total. Each channel also reports one status bit that says whether its FIFO sits above or below the half-full point. The controller only observes and commands. The interpolators and FIFOs live outside the block.

After `start_cal`, every channel is walked in turn, first the mission channels from index 0 upward and then the mirror channel. Each is stepped until its status bit reverses, which puts each FIFO at its half-full boundary and makes the latencies equal. From then on the mission interpolators are never touched, so no jitter reaches the line. The mirror channel is re-centred over and over. The signed number of steps each re-centring takes is added to a running total, and the total is published as the latency drift in interpolator steps. One step is one unit interval divided by 32. Timestamp logic downstream applies the total as a correction. If calibration cannot find the boundary within a set number of steps, an error is raised.

Top module: `mirror_lat_tracker`

## Requirements
- R1: After reset, all step outputs, `cal_done`, `cal_timeout` and `lat_valid` are 0 and `lat_steps` is 0. No step is issued until `start_cal` is seen.
- R2: During calibration, a channel whose synchronised `half_flag` was 1 (above half full) when its run began gets `pi_dn` pulses. A channel whose flag was 0 gets `pi_up` pulses. Stepping continues until the synchronised flag differs from that starting value. A channel that starts above half therefore ends exactly at the boundary, and one that starts below ends one step past it.
- R3: Channels are calibrated strictly in order: mission channels 0 to N_MIS-1, then the mirror channel (index N_MIS). At most one step output is high in any cycle. Consecutive steps are at least `cfg_gap`+3 cycles apart. Each step pulse lasts one cycle.
- R4: If a calibrating channel has received `cfg_limit` steps (at least one) without its flag reversing, `cal_timeout` goes to 1 and all stepping stops. `cal_done` stays 0. A new `start_cal` clears `cal_timeout` and restarts from channel 0.
- R5: Once `cal_done` is 1, no mission channel receives a step. A `start_cal` pulse during calibration or tracking has no effect.
- R6: In tracking, the mirror channel is stepped toward its boundary following the R2 direction rule. At each flag reversal, the signed count of steps in that round is added to `lat_steps`, counting up as +1 and down as -1. `lat_steps` is a two's-complement value, it is cleared to 0 when calibration completes, and so it equals net mirror steps (up minus down) since calibration.
- R7: `lat_valid` is a one-cycle strobe that coincides with each new `lat_steps` value. `lat_steps` never changes in a cycle without `lat_valid`. `lat_valid` is only ever 1 while `cal_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cal | input | 1 | Begin calibration (accepted when idle or after a timeout) |
| cfg_gap | input | GAP_W | Settle cycles between a step and the flag check |
| cfg_limit | input | LIM_W | Calibration step limit per channel |
| half_flag | input | N_MIS+1 | Asynchronous FIFO-above-half flags; top bit is the mirror |
| pi_up | output | N_MIS+1 | One-cycle phase step up per channel |
| pi_dn | output | N_MIS+1 | One-cycle phase step down per channel |
| cal_done | output | 1 | Calibration complete, tracking active |
| cal_timeout | output | 1 | Calibration step limit reached |
| lat_steps | output | ACC_W | Accumulated signed mirror drift in steps |
| lat_valid | output | 1 | Strobe marking a new `lat_steps` value |

## Verification
The bench starts channels both above and below the boundary, including one exactly at the boundary, which needs a single upward step. A design that picked the wrong direction would run away into the timeout, and one that stopped a step early or late would leave the FIFO off its boundary. Drift is applied equally to every channel, with zero, large positive, large negative and random values, and the published total is compared with the modelled drift. A sign error or a missed round shows up as a wrong total, and stray mission steps break the frozen-channel rule. A timeout run checks that exactly `cfg_limit` steps are issued and then nothing more. Such a run would catch a limit that is off by one or a sequencer that keeps stepping after the error.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROBE,
      ST_STEP,
      ST_WAIT,
      ST_CHECK,
      ST_FAIL
   } seq_st_e;
endpackage

// File: rtl/mlt_flag_sync.sv
module mlt_flag_sync #(
   parameter int NCH = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] flag_a,
   output logic [NCH-1:0] flag_s
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic meta_q;
      logic sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
         end else begin
            meta_q <= flag_a[c];
            sync_q <= meta_q;
         end
      end
      assign flag_s[c] = sync_q;
   end
endmodule

// File: rtl/mlt_seq.sv
module mlt_seq
   import mlt_pkg::*;
#(
   parameter int NCH   = 3,
   parameter int GAP_W = 8,
   parameter int LIM_W = 16,
   parameter int ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_cal,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic [LIM_W-1:0] cfg_limit,
   input  logic [NCH-1:0]   flag_s,
   output logic [NCH-1:0]   pi_up,
   output logic [NCH-1:0]   pi_dn,
   output logic             cal_done,
   output logic             cal_timeout,
   output logic             acc_clr,
   output logic             acc_add,
   output logic [ACC_W-1:0] acc_delta
);
   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [CH_W-1:0] MIR_IDX = CH_W'(NCH - 1);

   seq_st_e          st;
   logic [CH_W-1:0]  ch;
   logic             tracking;
   logic             ref_flag;
   logic [LIM_W-1:0] cal_steps;
   logic [GAP_W-1:0] wait_cnt;
   logic [ACC_W-1:0] run_cnt;
   logic             crossed;

   assign crossed = (flag_s[ch] != ref_flag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         ch          <= '0;
         tracking    <= 1'b0;
         ref_flag    <= 1'b0;
         cal_steps   <= '0;
         wait_cnt    <= '0;
         run_cnt     <= '0;
         cal_done    <= 1'b0;
         cal_timeout <= 1'b0;
      end else begin
         case (st)
            ST_IDLE, ST_FAIL: begin
               if (start_cal) begin
                  ch          <= '0;
                  tracking    <= 1'b0;
                  cal_timeout <= 1'b0;
                  st          <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               ref_flag  <= flag_s[ch];
               cal_steps <= '0;
               run_cnt   <= '0;
               st        <= ST_STEP;
            end
            ST_STEP: begin
               if (!tracking) cal_steps <= cal_steps + 1'b1;
               run_cnt  <= ref_flag ? run_cnt - 1'b1 : run_cnt + 1'b1;
               wait_cnt <= '0;
               st       <= ST_WAIT;
            end
            ST_WAIT: begin
               if (wait_cnt >= cfg_gap) st <= ST_CHECK;
               else wait_cnt <= wait_cnt + 1'b1;
            end
            ST_CHECK: begin
               if (crossed) begin
                  st <= ST_PROBE;
                  if (!tracking) begin
                     if (ch == MIR_IDX) begin
                        tracking <= 1'b1;
                        cal_done <= 1'b1;
                     end else begin
                        ch <= ch + 1'b1;
                     end
                  end
               end else if (!tracking && cal_steps >= cfg_limit) begin
                  cal_timeout <= 1'b1;
                  st          <= ST_FAIL;
               end else begin
                  st <= ST_STEP;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign pi_up     = (st == ST_STEP && !ref_flag) ? (NCH'(1) << ch) : '0;
   assign pi_dn     = (st == ST_STEP &&  ref_flag) ? (NCH'(1) << ch) : '0;
   assign acc_add   = (st == ST_CHECK) && tracking && crossed;
   assign acc_clr   = (st == ST_CHECK) && !tracking && crossed && (ch == MIR_IDX);
   assign acc_delta = run_cnt;
endmodule

// File: rtl/mlt_accum.sv
module mlt_accum #(
   parameter int ACC_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [ACC_W-1:0] delta,
   output logic [ACC_W-1:0] total,
   output logic             total_vld
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total     <= '0;
         total_vld <= 1'b0;
      end else begin
         total_vld <= add;
         if (clr)      total <= '0;
         else if (add) total <= total + delta;
      end
   end
endmodule

// File: rtl/mirror_lat_tracker.sv
module mirror_lat_tracker #(
   parameter int N_MIS = 2,
   parameter int GAP_W = 8,
   parameter int LIM_W = 16,
   parameter int ACC_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_cal,
   input  logic [GAP_W-1:0]   cfg_gap,
   input  logic [LIM_W-1:0]   cfg_limit,
   input  logic [N_MIS:0]     half_flag,
   output logic [N_MIS:0]     pi_up,
   output logic [N_MIS:0]     pi_dn,
   output logic               cal_done,
   output logic               cal_timeout,
   output logic [ACC_W-1:0]   lat_steps,
   output logic               lat_valid
);
   localparam int NCH = N_MIS + 1;

   if (N_MIS < 1) begin : g_bad_nmis
      $error("N_MIS must be at least 1");
   end
   if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
      $error("GAP_W out of range");
   end
   if (LIM_W < 2) begin : g_bad_lim
      $error("LIM_W too small");
   end
   if (ACC_W < 8) begin : g_bad_acc
      $error("ACC_W too small");
   end

   logic [NCH-1:0]   flag_s;
   logic             acc_clr;
   logic             acc_add;
   logic [ACC_W-1:0] acc_delta;

   mlt_flag_sync #(.NCH(NCH)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_a (half_flag),
      .flag_s (flag_s)
   );

   mlt_seq #(.NCH(NCH), .GAP_W(GAP_W), .LIM_W(LIM_W), .ACC_W(ACC_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_cal   (start_cal),
      .cfg_gap     (cfg_gap),
      .cfg_limit   (cfg_limit),
      .flag_s      (flag_s),
      .pi_up       (pi_up),
      .pi_dn       (pi_dn),
      .cal_done    (cal_done),
      .cal_timeout (cal_timeout),
      .acc_clr     (acc_clr),
      .acc_add     (acc_add),
      .acc_delta   (acc_delta)
   );

   mlt_accum #(.ACC_W(ACC_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (acc_clr),
      .add       (acc_add),
      .delta     (acc_delta),
      .total     (lat_steps),
      .total_vld (lat_valid)
   );
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
   parameter int N_MIS = 2,
   parameter int ACC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_MIS:0]   pi_up,
   input logic [N_MIS:0]   pi_dn,
   input logic             cal_done,
   input logic             cal_timeout,
   input logic [ACC_W-1:0] lat_steps,
   input logic             lat_valid
);
   // R3
   one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pi_up, pi_dn}));

   // R3
   step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|{pi_up, pi_dn}) |=> !(|{pi_up, pi_dn}));

   // R5
   mission_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> (pi_up[N_MIS-1:0] == '0 && pi_dn[N_MIS-1:0] == '0));

   // R4
   timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cal_done && cal_timeout));

   // R4
   timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_timeout |-> !(|{pi_up, pi_dn}));

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid |=> !lat_valid);

   // R7
   valid_tracking_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_valid |-> cal_done);

   // R7
   lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && !lat_valid && $past(cal_done) && $past(rst_n)) |-> $stable(lat_steps));
endmodule

bind mirror_lat_tracker mlt_checker #(.N_MIS(N_MIS), .ACC_W(ACC_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .pi_up       (pi_up),
   .pi_dn       (pi_dn),
   .cal_done    (cal_done),
   .cal_timeout (cal_timeout),
   .lat_steps   (lat_steps),
   .lat_valid   (lat_valid)
);

// File: tb/mirror_lat_tracker_tb_top.sv
module mirror_lat_tracker_tb_top;
   localparam int CLK_P = 10;
   localparam int N_MIS = 2;
   localparam int NCH   = N_MIS + 1;
   localparam int MIR   = N_MIS;
   localparam int GAP   = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_cal = 1'b0;
   logic [7:0]     cfg_gap = 8'(GAP);
   logic [15:0]    cfg_limit = 16'd20;
   logic [NCH-1:0] half_flag;
   logic [NCH-1:0] pi_up, pi_dn;
   logic           cal_done, cal_timeout, lat_valid;
   logic [23:0]    lat_steps;

   int n_chk = 0, n_err = 0;
   int ups[NCH], dns[NCH], base[NCH];
   int drift = 0;
   int cyc = 0, last_step = -1, min_space = 1000000;
   int mis_after = 0, vcount = 0, dbl_valid = 0, lat_bad = 0;
   int lat_snap = 0, eff_snap = 0, net_snap = 0;
   logic prev_valid = 1'b0;
   logic [23:0] prev_lat = '0;

   always #(CLK_P/2) clk = ~clk;

   mirror_lat_tracker #(.N_MIS(N_MIS)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_cal(start_cal), .cfg_gap(cfg_gap),
      .cfg_limit(cfg_limit), .half_flag(half_flag), .pi_up(pi_up), .pi_dn(pi_dn),
      .cal_done(cal_done), .cal_timeout(cal_timeout), .lat_steps(lat_steps),
      .lat_valid(lat_valid)
   );

   // FIFO / interpolator model: up raises fill, flag = above half
   always_comb begin
      for (int c = 0; c < NCH; c++)
         half_flag[c] = (ups[c] - dns[c] + base[c] + drift) > 0;
   end

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin ups[c] = 0; dns[c] = 0; end
         last_step = -1;
         prev_valid = 1'b0;
         prev_lat = '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (pi_up[c]) ups[c]++;
            if (pi_dn[c]) dns[c]++;
         end
         if (|{pi_up, pi_dn}) begin
            if (last_step >= 0 && cyc - last_step < min_space) min_space = cyc - last_step;
            last_step = cyc;
            if (cal_done && (|{pi_up[N_MIS-1:0], pi_dn[N_MIS-1:0]})) mis_after++;
         end
         if (lat_valid) begin
            vcount++;
            lat_snap = int'($signed(lat_steps));
            eff_snap = ups[MIR] - dns[MIR] + base[MIR] + drift;
            net_snap = ups[MIR] - dns[MIR];
         end
         if (lat_valid && prev_valid) dbl_valid++;
         if (!lat_valid && lat_steps != prev_lat) lat_bad++;
         prev_valid = lat_valid;
         prev_lat = lat_steps;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_steps(input int e);
      return (e > 0) ? e : 1 - e;
   endfunction

   function automatic int exp_final(input int e);
      return (e > 0) ? 0 : 1;
   endfunction

   function automatic int eff(input int c);
      return ups[c] - dns[c] + base[c] + drift;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic pulse_start();
      @(posedge clk); #2 start_cal = 1'b1;
      @(posedge clk); #2 start_cal = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (cal_done) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_valids(input int n, output bit ok);
      int target;
      target = vcount + n;
      ok = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (vcount >= target) begin ok = 1'b1; break; end
      end
      #2;
   endtask

   initial begin
      int e[NCH];
      int eff_c, net_c, d, seed_dummy;
      bit ok;
      seed_dummy = $urandom(32'h5A17);
      for (int c = 0; c < NCH; c++) begin base[c] = 0; ups[c] = 0; dns[c] = 0; end

      // reset state
      do_reset();
      repeat (3) @(posedge clk);
      #2;
      check(pi_up == 0 && pi_dn == 0, "R1", "no steps after reset", int'({pi_up, pi_dn}), 0);
      check(!cal_done && !cal_timeout && !lat_valid, "R1", "status after reset",
            int'({cal_done, cal_timeout, lat_valid}), 0);
      check(lat_steps == 0, "R1", "latency after reset", int'(lat_steps), 0);

      // timeout: mission 0 far above half, limit 20
      base[0] = 50; base[1] = 0; base[2] = 0;
      cfg_limit = 16'd20;
      pulse_start();
      for (int i = 0; i < 5000 && !cal_timeout; i++) @(posedge clk);
      #2;
      check(cal_timeout == 1'b1, "R4", "timeout raised", int'(cal_timeout), 1);
      check(dns[0] == 20 && ups[0] == 0, "R4", "steps before timeout", dns[0], 20);
      check(ups[1] + dns[1] + ups[2] + dns[2] == 0, "R3", "later channels untouched",
            ups[1] + dns[1] + ups[2] + dns[2], 0);
      check(!cal_done, "R4", "no done on timeout", int'(cal_done), 0);
      repeat (60) @(posedge clk);
      #2;
      check(dns[0] == 20, "R4", "stepping stopped after timeout", dns[0], 20);

      // restart clears the error; ch0 starts exactly at the boundary (flag 0)
      cfg_limit = 16'd1000;
      base[0] = 0 - (ups[0] - dns[0]);
      pulse_start();
      #2;
      check(!cal_timeout, "R4", "timeout cleared by restart", int'(cal_timeout), 0);
      wait_done(ok);
      #2;
      check(ok, "R2", "recalibration completes", int'(ok), 1);
      check(eff(0) == 1, "R2", "boundary start ends one above", eff(0), 1);

      // random calibrations with reset between
      for (int it = 0; it < 4; it++) begin
         do_reset();
         for (int c = 0; c < NCH; c++) begin
            e[c] = int'($urandom_range(80)) - 40;
            base[c] = e[c];
         end
         if (it == 0) begin e[0] = 1; base[0] = 1; end
         pulse_start();
         wait_done(ok);
         #2;
         check(ok, "R2", "calibration done", int'(ok), 1);
         for (int c = 0; c < NCH; c++) begin
            check(ups[c] + dns[c] == exp_steps(e[c]), "R2", $sformatf("ch%0d step count", c),
                  ups[c] + dns[c], exp_steps(e[c]));
            check(eff(c) == exp_final(e[c]), "R2", $sformatf("ch%0d final position", c),
                  eff(c), exp_final(e[c]));
         end
         check(lat_steps == 0, "R6", "total cleared at calibration end", int'(lat_steps), 0);
      end

      // tracking with drift applied to every channel
      eff_c = eff(MIR);
      net_c = ups[MIR] - dns[MIR];
      for (int k = 0; k < 10; k++) begin
         if (k == 0) d = 0;
         else if (k == 1) d = 37;
         else if (k == 2) d = -60;
         else d = int'($urandom_range(50)) - 25;
         @(posedge clk); #2 drift = drift + d;
         if (k == 4) begin
            start_cal = 1'b1;
            @(posedge clk); #2 start_cal = 1'b0;
         end
         wait_valids(2, ok);
         check(ok, "R6", "measurements keep coming", int'(ok), 1);
         check(eff_snap == 0 || eff_snap == 1, "R6", "mirror re-centred", eff_snap, 0);
         check(lat_snap == -drift + eff_snap - eff_c, "R6", "total tracks drift",
               lat_snap, -drift + eff_snap - eff_c);
         check(lat_snap == net_snap - net_c, "R6", "total equals net mirror steps",
               lat_snap, net_snap - net_c);
         check(mis_after == 0, "R5", "mission frozen", mis_after, 0);
         check(cal_done && !cal_timeout, "R5", "start during tracking ignored",
               int'({cal_done, cal_timeout}), 2);
      end

      check(min_space >= GAP + 3, "R3", "step spacing", min_space, GAP + 3);
      check(dbl_valid == 0, "R7", "valid is one cycle", dbl_valid, 0);
      check(lat_bad == 0, "R7", "latency changes only with valid", lat_bad, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule